// File: doc/BRIEF.md
# Protection Region Address Range Decoder

This block takes one protection entry and turns it into an inclusive byte-address window. Its inputs are the entry's configuration byte, the entry's own address register, and the address register of the entry just below it. Address registers hold a physical byte address divided by four. The block is purely combinational. A region checker instantiates one copy per entry and compares each access against the `rng_lo`..`rng_hi` window that the copy produces.

The block supports four match modes. A disabled entry reports the whole address space and deasserts `rng_valid`, so the consumer must mask it. A top-of-range entry spans from the previous entry's boundary up to its own boundary. An inverted or zero-width window collapses to an empty range. A single-word entry covers exactly four bytes. A power-of-two entry encodes its size in the count of trailing ones in the address register. The output window is one bit wider than the shifted address, so the largest power-of-two region is still represented exactly.

Top module: `pmp_range_decode`

## Requirements
- R1: The match mode is taken from bits [4:3] of `cfg_byte`: 0 disabled, 1 top-of-range, 2 single 4-byte word, 3 power-of-two. The other six bits of `cfg_byte` have no effect on any output.
- R2: In disabled mode `rng_lo` is 0, `rng_hi` is all ones across its full width, and `rng_valid` is 0.
- R3: In top-of-range mode with `addr_cur` greater than the effective previous address, `rng_lo` = previous×4, `rng_hi` = `addr_cur`×4−1, and `rng_valid` is 1.
- R4: In top-of-range mode with `addr_cur` less than or equal to the effective previous address (including `addr_cur` = 0), `rng_lo` and `rng_hi` are both 0 and `rng_valid` is 0.
- R5: When `head_entry` is 1, the effective previous address is 0 whatever `addr_prev` holds. When `head_entry` is 0, it is `addr_prev`.
- R6: In single-word mode `rng_lo` = `addr_cur`×4 and `rng_hi` = `rng_lo`+3.
- R7: In power-of-two mode, with k the count of trailing ones in `addr_cur`, the region size is 2^(k+3) bytes. `rng_lo` is `addr_cur`×4 with its low k+3 bits cleared, and `rng_hi` = `rng_lo` + size − 1.
- R8: With `addr_cur` all ones in power-of-two mode, `rng_lo` is 0 and `rng_hi` is all ones across its AW+3 bits. The top bit of `rng_lo` is never set in any mode.
- R9: `rng_valid` is 1 in single-word and power-of-two modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_byte | input | 8 | Entry configuration byte; mode in bits [4:3] |
| addr_cur | input | AW | This entry's address register (byte address / 4) |
| addr_prev | input | AW | Previous entry's address register |
| head_entry | input | 1 | High for the lowest entry, which has no predecessor |
| rng_lo | output | AW+3 | Inclusive start byte address |
| rng_hi | output | AW+3 | Inclusive end byte address |
| rng_valid | output | 1 | Window is live (not disabled, not collapsed) |

## Verification
The assertions are immediate and combinational. They assume that the inputs settle to known values, and that all outputs are read after the combinational paths have resolved. They check shapes rather than exact values: the four-byte span, power-of-two size and alignment, order of the top-of-range bounds, and a clear top bit on the start address. The bench drives every vector half a cycle away from the sampling point and starts from all-zero inputs, so no check sees unknown values. The random stimulus picks the mode field uniformly and fills the other configuration bits at random. Directed vectors cover equal, inverted and zero top-of-range boundaries, the head entry, the largest single word, and trailing-ones lengths of 0, 1, 2 and the full width.

// File: rtl/pmp_rng_pkg.sv
// Shared types for the protection region range decoder.
// Assumes the mode field sits at bits [4:3] of the configuration byte.
package pmp_rng_pkg;
    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amatch_e;

    localparam int unsigned AM_LSB = 3;
endpackage

// File: rtl/pmp_tor_window.sv
// Top-of-range window: spans previous boundary up to own boundary minus one.
// Assumes both address registers are word addresses (byte address / 4).
// A zero-width or inverted window is reported empty with both bounds at 0.
module pmp_tor_window #(
    parameter int unsigned AW = 32,
    localparam int unsigned RW = AW + 3
) (
    input  logic [AW-1:0] addr_cur,
    input  logic [AW-1:0] addr_prev,
    input  logic          head_entry,
    output logic [RW-1:0] win_lo,
    output logic [RW-1:0] win_hi,
    output logic          win_empty
);
    logic [AW-1:0] prev_eff;
    logic [RW-1:0] lo_raw;
    logic [RW-1:0] hi_raw;

    // Choose the lower boundary; the head entry starts at address zero.
    always_comb begin
        prev_eff = head_entry ? '0 : addr_prev;
    end

    // Form raw byte bounds and collapse when the window has no bytes.
    always_comb begin
        lo_raw    = {1'b0, prev_eff, 2'b00};
        hi_raw    = {1'b0, addr_cur, 2'b00} - RW'(1);
        win_empty = (addr_cur <= prev_eff);
        win_lo    = win_empty ? '0 : lo_raw;
        win_hi    = win_empty ? '0 : hi_raw;
    end
endmodule

// File: rtl/pmp_pow2_window.sv
// Naturally aligned window: a single 4-byte word, or a power-of-two block
// whose size is coded by trailing ones in the address register.
// Assumes RW is one bit wider than the shifted address so no carry is lost.
module pmp_pow2_window #(
    parameter int unsigned AW = 32,
    localparam int unsigned RW = AW + 3
) (
    input  logic [AW-1:0] addr_cur,
    input  logic          word_only,
    output logic [RW-1:0] win_lo,
    output logic [RW-1:0] win_hi
);
    logic [RW-1:0] base;
    logic [RW-1:0] filled;
    logic [RW-1:0] filled_inc;

    // Fill the two implied low bits so the trailing-ones run is complete.
    always_comb begin
        base       = {1'b0, addr_cur, 2'b00};
        filled     = base | RW'(3);
        filled_inc = filled + RW'(1);
    end

    // Clear or set the whole trailing-ones run to find the block bounds.
    always_comb begin
        if (word_only) begin
            win_lo = base;
            win_hi = filled;
        end else begin
            win_lo = filled & filled_inc;
            win_hi = filled | filled_inc;
        end
    end
endmodule

// File: rtl/pmp_range_select.sv
// Picks the window for the active mode and derives the live flag.
// Assumes the two window generators are computed in parallel.
module pmp_range_select
    import pmp_rng_pkg::*;
#(
    parameter int unsigned AW = 32,
    localparam int unsigned RW = AW + 3
) (
    input  amatch_e       mode,
    input  logic [RW-1:0] tor_lo,
    input  logic [RW-1:0] tor_hi,
    input  logic          tor_empty,
    input  logic [RW-1:0] p2_lo,
    input  logic [RW-1:0] p2_hi,
    output logic [RW-1:0] sel_lo,
    output logic [RW-1:0] sel_hi,
    output logic          sel_valid
);
    // Route the mode's window to the outputs.
    always_comb begin
        unique case (mode)
            AM_OFF: begin
                sel_lo    = '0;
                sel_hi    = '1;
                sel_valid = 1'b0;
            end
            AM_TOR: begin
                sel_lo    = tor_lo;
                sel_hi    = tor_hi;
                sel_valid = !tor_empty;
            end
            default: begin
                sel_lo    = p2_lo;
                sel_hi    = p2_hi;
                sel_valid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pmp_range_decode.sv
// Converts one protection entry into an inclusive byte-address window.
// Assumes word-granular address registers and a mode field at cfg[4:3];
// all other configuration bits are left to other logic.
module pmp_range_decode
    import pmp_rng_pkg::*;
#(
    parameter int unsigned AW = 32,
    localparam int unsigned RW = AW + 3
) (
    input  logic [7:0]    cfg_byte,
    input  logic [AW-1:0] addr_cur,
    input  logic [AW-1:0] addr_prev,
    input  logic          head_entry,
    output logic [RW-1:0] rng_lo,
    output logic [RW-1:0] rng_hi,
    output logic          rng_valid
);
    amatch_e       mode;
    logic [RW-1:0] tor_lo;
    logic [RW-1:0] tor_hi;
    logic          tor_empty;
    logic [RW-1:0] p2_lo;
    logic [RW-1:0] p2_hi;
    logic          unused_cfg_bits;

    // Extract the match mode; remaining bits belong to other logic.
    always_comb begin
        mode            = amatch_e'(cfg_byte[AM_LSB+1:AM_LSB]);
        unused_cfg_bits = ^{cfg_byte[7:AM_LSB+2], cfg_byte[AM_LSB-1:0]};
    end

    pmp_tor_window #(.AW(AW)) u_tor (
        .addr_cur  (addr_cur),
        .addr_prev (addr_prev),
        .head_entry(head_entry),
        .win_lo    (tor_lo),
        .win_hi    (tor_hi),
        .win_empty (tor_empty)
    );

    pmp_pow2_window #(.AW(AW)) u_pow2 (
        .addr_cur (addr_cur),
        .word_only(mode == AM_NA4),
        .win_lo   (p2_lo),
        .win_hi   (p2_hi)
    );

    pmp_range_select #(.AW(AW)) u_sel (
        .mode     (mode),
        .tor_lo   (tor_lo),
        .tor_hi   (tor_hi),
        .tor_empty(tor_empty),
        .p2_lo    (p2_lo),
        .p2_hi    (p2_hi),
        .sel_lo   (rng_lo),
        .sel_hi   (rng_hi),
        .sel_valid(rng_valid)
    );
endmodule

// File: rtl/pmp_range_decode_chk.sv
// Shape checks on the decoded window, bound to the top module.
// Assumes inputs are settled; all checks are combinational.
module pmp_range_decode_chk #(
    parameter int unsigned AW = 32,
    localparam int unsigned RW = AW + 3
) (
    input logic [7:0]    cfg_byte,
    input logic [RW-1:0] rng_lo,
    input logic [RW-1:0] rng_hi,
    input logic          rng_valid
);
    logic [1:0]    am;
    logic [RW-1:0] span;

    // Evaluate every window property on each input change.
    always_comb begin
        am   = cfg_byte[4:3];
        span = rng_hi - rng_lo;
        // R2: disabled entries report the full space and are not live
        p_off_full_r2: assert (am != 2'd0 || (rng_lo == '0 && rng_hi == '1 && !rng_valid));
        // R3: a live top-of-range window is ordered and word aligned
        p_tor_order_r3: assert (am != 2'd1 || !rng_valid
                                || (rng_lo <= rng_hi && rng_lo[1:0] == 2'b00 && rng_hi[1:0] == 2'b11));
        // R4: a dead top-of-range window has both bounds at zero
        p_tor_empty_r4: assert (am != 2'd1 || rng_valid || (rng_lo == '0 && rng_hi == '0));
        // R6: single word covers four bytes
        p_word_span_r6: assert (am != 2'd2 || (span == RW'(3) && rng_lo[1:0] == 2'b00));
        // R7: power-of-two block is aligned to its own size, at least eight bytes
        p_pow2_shape_r7: assert (am != 2'd3
                                 || ((((span + RW'(1)) & span) == '0) && ((rng_lo & span) == '0)
                                     && span >= RW'(7)));
        // R8: start address never uses the guard bit
        p_no_overflow_r8: assert (rng_lo[RW-1] == 1'b0);
        // R9: aligned modes are always live
        p_aligned_live_r9: assert (am[1] == 1'b0 || rng_valid);
    end
endmodule

bind pmp_range_decode pmp_range_decode_chk #(.AW(AW)) u_chk (
    .cfg_byte (cfg_byte),
    .rng_lo   (rng_lo),
    .rng_hi   (rng_hi),
    .rng_valid(rng_valid)
);

// File: tb/test_pmp_range_decode.sv
module test_pmp_range_decode;
    localparam int unsigned AW = 32;
    localparam int unsigned RW = AW + 3;

    logic          clk = 1'b0;
    logic [7:0]    cfg_byte = '0;
    logic [AW-1:0] addr_cur = '0;
    logic [AW-1:0] addr_prev = '0;
    logic          head_entry = 1'b0;
    logic [RW-1:0] rng_lo;
    logic [RW-1:0] rng_hi;
    logic          rng_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pmp_range_decode #(.AW(AW)) i_pmp_range_decode (
        .cfg_byte  (cfg_byte),
        .addr_cur  (addr_cur),
        .addr_prev (addr_prev),
        .head_entry(head_entry),
        .rng_lo    (rng_lo),
        .rng_hi    (rng_hi),
        .rng_valid (rng_valid)
    );

    // Independent model of the window from the requirements.
    function automatic void model(input logic [7:0] c, input logic [AW-1:0] cur,
                                  input logic [AW-1:0] prv, input logic hd,
                                  output logic [63:0] lo, output logic [63:0] hi,
                                  output logic v);
        logic [63:0] p, base, size;
        int k;
        p = hd ? 64'd0 : 64'(prv);
        base = 64'(cur) * 4;
        case (c[4:3])
            2'd0: begin lo = 0; hi = (64'd1 << RW) - 1; v = 0; end
            2'd1: begin
                if (64'(cur) > p) begin lo = p * 4; hi = base - 1; v = 1; end
                else begin lo = 0; hi = 0; v = 0; end
            end
            2'd2: begin lo = base; hi = base + 3; v = 1; end
            default: begin
                k = 0;
                while (k < AW && cur[k]) k++;
                size = 64'd1 << (k + 3);
                lo = base & ~(size - 1);
                hi = lo + size - 1;
                v = 1;
            end
        endcase
    endfunction

    task automatic apply(input logic [7:0] c, input logic [AW-1:0] cur,
                         input logic [AW-1:0] prv, input logic hd, input string tag);
        logic [63:0] elo, ehi;
        logic ev;
        @(negedge clk);
        cfg_byte = c; addr_cur = cur; addr_prev = prv; head_entry = hd;
        @(posedge clk);
        #1;
        model(c, cur, prv, hd, elo, ehi, ev);
        n_checks++;
        if (64'(rng_lo) != elo || 64'(rng_hi) != ehi || rng_valid != ev) begin
            n_fail++;
            $display("FAIL %s: got lo=%h hi=%h v=%0b expected lo=%h hi=%h v=%0b",
                     tag, rng_lo, rng_hi, rng_valid, elo[RW-1:0], ehi[RW-1:0], ev);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        // R2: all-zero inputs give a disabled entry
        apply(8'h00, '0, '0, 1'b0, "R2 initial off");
        apply(8'hE7, 32'h1234_5678, 32'h0, 1'b0, "R2 off with other bits");
        // R3: ordinary top-of-range windows
        apply(8'h08, 32'h0000_0100, 32'h0000_0040, 1'b0, "R3 tor basic");
        apply(8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, "R3 tor top");
        // R4: equal, inverted and zero boundaries collapse
        apply(8'h08, 32'h0000_0080, 32'h0000_0080, 1'b0, "R4 tor equal");
        apply(8'h08, 32'h0000_0010, 32'h0000_0080, 1'b0, "R4 tor inverted");
        apply(8'h08, 32'h0, 32'h0, 1'b1, "R4 tor zero");
        // R5: head entry ignores the previous register
        apply(8'h08, 32'h0000_0010, 32'h0000_0080, 1'b1, "R5 head entry");
        apply(8'h08, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, "R5 head min");
        // R6: single word, including the top word
        apply(8'h10, 32'h2000_0003, 32'h0, 1'b0, "R6 word");
        apply(8'h10, 32'hFFFF_FFFF, 32'h0, 1'b0, "R6 word max");
        // R7: trailing-ones lengths 0, 1, 2
        apply(8'h18, 32'h2000_0000, 32'h0, 1'b0, "R7 pow2 8B");
        apply(8'h18, 32'h2000_0001, 32'h0, 1'b0, "R7 pow2 16B");
        apply(8'h18, 32'h2000_0003, 32'h0, 1'b0, "R7 pow2 32B");
        apply(8'h18, 32'h7FFF_FFFF, 32'h0, 1'b0, "R7 pow2 half space");
        // R8: all-ones block fills the widened range
        apply(8'h18, 32'hFFFF_FFFF, 32'h0, 1'b0, "R8 pow2 all ones");
        // R1: non-mode bits do not change the outcome
        apply(8'hFF, 32'h0000_00FF, 32'h0, 1'b0, "R1 ignored bits pow2");
        apply(8'hCD, 32'h0000_0400, 32'h0000_0100, 1'b0, "R1 ignored bits tor");
        apply(8'h97, 32'h0000_0400, 32'h0, 1'b0, "R1 ignored bits word");
        // R9 and all modes: constrained random with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] rc, rp;
            c = 8'($urandom);
            rc = $urandom;
            rp = $urandom;
            if (i % 4 == 0) rc = rc >> ($urandom % 32);
            if (i % 5 == 0) rp = rc;
            apply(c, rc, rp, 1'($urandom % 8 == 0), "R9 random mode");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule